// File: doc/BRIEF.md
# DRAM Refresh Row Counter with Self-Refresh Timer

This block holds the row counter that a DRAM uses for its own refresh. When the controller asks for a refresh on the refresh pin, the counter value is the row that gets refreshed. The counter advances by one when that cycle ends, so the next request hits the next row. Across 1024 rows and a 64 ms retention window, the array needs at least 1024 of these cycles in every window.

In self-refresh mode, an on-chip timer issues refresh cycles without any external request, and these cycles walk the same counter. Self-refresh ends when the row strobe drops. A busy flag then stays high until any refresh pulse still running has finished and a fixed recovery count has elapsed. A new operation is accepted only after that. The block sees the row strobe as an active-high level sampled on the clock. The array timing itself is outside this block.

Top module: `refr_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, `row_o` is 0, `ref_stb_o` is 0 and `busy_o` is 0.
- R2: A rising edge of `rstb_i` with `ref_req_i`=1 and `self_en_i`=0, while `busy_o` is 0, starts an external refresh. From the next cycle, `ref_stb_o` and `busy_o` are 1 and `row_o` shows the current counter value.
- R3: An external refresh ends at the first clock edge at which `rstb_i` is 0. After that edge, `ref_stb_o` is 0 and `row_o` is one higher.
- R4: The row counter is `ROW_W` bits wide (10 by default) and wraps from its all-ones value to 0.
- R5: A rising edge of `rstb_i` with both `ref_req_i` and `self_en_i` at 0 changes neither the row nor the strobe, and does not raise the busy flag.
- R6: A rising edge of `rstb_i` with `self_en_i`=1 enters self-refresh. While `rstb_i` stays 1, a timer issues one internal refresh every `PERIOD_CYC` cycles. The first one comes `PERIOD_CYC` cycles after the entry edge. Each one holds `ref_stb_o` for `PULSE_CYC` cycles, and the row advances on the edge that ends it.
- R7: If `self_en_i` and `ref_req_i` are both 1 on the entry edge, self-refresh is chosen. No immediate strobe appears, but `busy_o` rises.
- R8: On the edge at which `rstb_i` is seen at 0 in self-refresh, the mode ends. `busy_o` then stays 1 for `RECOV_CYC` cycles after that edge, and also until any running pulse completes.
- R9: A rising edge of `rstb_i` while `busy_o` is 1 is ignored. No refresh starts and the row is unchanged.
- R10: `row_o` changes only at the end of a refresh, and always by exactly +1 modulo the counter size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req_i | input | 1 | Decoded refresh request, sampled on the strobe rising edge |
| self_en_i | input | 1 | Self-refresh enable, sampled on the strobe rising edge |
| rstb_i | input | 1 | Row strobe, 1 = active |
| row_o | output | ROW_W | Refresh row address (the counter) |
| ref_stb_o | output | 1 | Internal refresh strobe |
| busy_o | output | 1 | A refresh, self-refresh or post-exit recovery is in progress |

## Verification
A corrupted row counter shows up on `row_o` at once, because the output is the counter itself. A skipped or doubled increment appears on the edge that ends the next refresh. An error in the timer or the pulse length shifts a `ref_stb_o` edge by one or more cycles, within one `PERIOD_CYC` of entry. A wrong recovery count moves the falling edge of `busy_o` after exit. A reference model that runs every cycle catches each of these on the first cycle where the outputs differ.

// File: rtl/refr_pkg.sv
package refr_pkg;
   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_EXT  = 2'd1,
      MODE_SELF = 2'd2
   } refr_mode_e;
endpackage

// File: rtl/refr_row_ctr.sv
module refr_row_ctr #(
   parameter int ROW_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [ROW_W-1:0] row_o
);
   localparam logic [ROW_W-1:0] ONE = ROW_W'(1);

   if (ROW_W < 1) begin : g_bad_w
      $error("refr_row_ctr: ROW_W must be at least 1");
   end

   logic [ROW_W-1:0] row_q;

   // binary counter; natural overflow gives the wrap to zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     row_q <= '0;
      else if (inc_i) row_q <= row_q + ONE;
   end

   assign row_o = row_q;
endmodule

// File: rtl/refr_self_timer.sv
module refr_self_timer #(
   parameter int PERIOD_CYC = 6250,
   parameter int PULSE_CYC  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic pulse_o,
   output logic done_o
);
   localparam int TW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
   localparam int PW = $clog2(PULSE_CYC + 1);
   localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);
   localparam logic [PW-1:0] PLEN = PW'(PULSE_CYC);
   localparam logic [PW-1:0] PONE = PW'(1);

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("refr_self_timer: PULSE_CYC must be at least 1");
   end
   if (PERIOD_CYC <= PULSE_CYC + 1) begin : g_bad_period
      $error("refr_self_timer: PERIOD_CYC must exceed PULSE_CYC + 1");
   end

   logic [TW-1:0] tick_q;
   logic [PW-1:0] pcnt_q;
   logic          fire;

   assign fire = run_i && (tick_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tick_q <= '0;
      else if (clr_i)  tick_q <= '0;
      else if (run_i)  tick_q <= fire ? '0 : tick_q + TW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pcnt_q <= '0;
      else if (fire)           pcnt_q <= PLEN;
      else if (pcnt_q != '0)   pcnt_q <= pcnt_q - PONE;
   end

   assign pulse_o = (pcnt_q != '0);
   assign done_o  = (pcnt_q == PONE);

   AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q <= LAST);                                                   // R6
   AST_PULSE_FROM_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_o) |-> $past(run_i));                                  // R6
endmodule

// File: rtl/refr_recovery.sv
module refr_recovery #(
   parameter int RECOV_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);
   if (RECOV_CYC < 1) begin : g_bad_rec
      $error("refr_recovery: RECOV_CYC must be at least 1");
   end

   if (RECOV_CYC == 1) begin : g_flop
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= load_i;
      end
      assign busy_o = busy_q;
   end else begin : g_count
      localparam int RW = $clog2(RECOV_CYC + 1);
      logic [RW-1:0] rc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           rc_q <= '0;
         else if (load_i)      rc_q <= RW'(RECOV_CYC);
         else if (rc_q != '0)  rc_q <= rc_q - RW'(1);
      end
      assign busy_o = (rc_q != '0);
   end
endmodule

// File: rtl/refr_ctl.sv
module refr_ctl
   import refr_pkg::*;
#(
   parameter int ROW_W      = 10,
   parameter int PERIOD_CYC = 6250,
   parameter int PULSE_CYC  = 4,
   parameter int RECOV_CYC  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_req_i,
   input  logic             self_en_i,
   input  logic             rstb_i,
   output logic [ROW_W-1:0] row_o,
   output logic             ref_stb_o,
   output logic             busy_o
);
   refr_mode_e mode_q, mode_d;
   logic rstb_q, rise, start_ok;
   logic ext_end, self_exit, tmr_clr, tmr_run;
   logic pulse_on, pulse_done, rec_busy, row_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rstb_q <= 1'b0;
      else        rstb_q <= rstb_i;
   end

   assign rise      = rstb_i && !rstb_q;
   assign busy_o    = (mode_q != MODE_IDLE) || pulse_on || rec_busy;
   assign start_ok  = rise && !busy_o;
   assign ext_end   = (mode_q == MODE_EXT)  && !rstb_i;
   assign self_exit = (mode_q == MODE_SELF) && !rstb_i;
   assign tmr_clr   = start_ok && self_en_i;
   assign tmr_run   = (mode_q == MODE_SELF) && rstb_i;
   assign row_inc   = ext_end || pulse_done;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_IDLE: if (start_ok) begin
            if (self_en_i)      mode_d = MODE_SELF;
            else if (ref_req_i) mode_d = MODE_EXT;
         end
         MODE_EXT:  if (ext_end)   mode_d = MODE_IDLE;
         MODE_SELF: if (self_exit) mode_d = MODE_IDLE;
         default:   mode_d = MODE_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_IDLE;
      else        mode_q <= mode_d;
   end

   refr_row_ctr #(.ROW_W(ROW_W)) u_row (
      .clk(clk), .rst_n(rst_n), .inc_i(row_inc), .row_o(row_o)
   );

   refr_self_timer #(.PERIOD_CYC(PERIOD_CYC), .PULSE_CYC(PULSE_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .run_i(tmr_run),
      .pulse_o(pulse_on), .done_o(pulse_done)
   );

   refr_recovery #(.RECOV_CYC(RECOV_CYC)) u_rec (
      .clk(clk), .rst_n(rst_n), .load_i(self_exit), .busy_o(rec_busy)
   );

   assign ref_stb_o = (mode_q == MODE_EXT) || pulse_on;

   AST_STB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ref_stb_o |-> busy_o);                                             // R2
   AST_END_INC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_stb_o) |-> row_o == ROW_W'($past(row_o) + ROW_W'(1)));   // R3
   AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_o) |-> row_o == ROW_W'($past(row_o) + ROW_W'(1)));    // R10
   AST_EXIT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      self_exit |=> busy_o);                                             // R8
   AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && busy_o && mode_q == MODE_IDLE) |=> mode_q == MODE_IDLE);  // R9
endmodule

// File: tb/sim_refr_ctl.sv
module sim_refr_ctl;
   localparam int ROW_W = 10;
   localparam int PER   = 24;
   localparam int PUL   = 3;
   localparam int REC   = 5;
   localparam int NROW  = 1 << ROW_W;

   logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, sen = 1'b0, s = 1'b0;
   logic [ROW_W-1:0] row;
   logic stb, busy;

   always #5 clk = ~clk;

   refr_ctl #(.ROW_W(ROW_W), .PERIOD_CYC(PER), .PULSE_CYC(PUL), .RECOV_CYC(REC)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_req_i(req), .self_en_i(sen), .rstb_i(s),
      .row_o(row), .ref_stb_o(stb), .busy_o(busy)
   );

   int vec = 0, bad = 0;

   task automatic chk(input string tag, input int act, input int exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // behavioural reference: 0 idle, 1 external, 2 self
   int m_row = 0, m_mode = 0, m_tmr = 0, m_pul = 0, m_rec = 0;
   bit m_sq = 0, m_rise, m_bz;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_row = 0; m_mode = 0; m_tmr = 0; m_pul = 0; m_rec = 0; m_sq = 0;
      end else begin
         m_rise = s && !m_sq;
         m_bz   = (m_mode != 0) || (m_pul != 0) || (m_rec != 0);
         if (m_pul != 0) begin
            if (m_pul == 1) m_row = (m_row + 1) % NROW;
            m_pul--;
         end
         if (m_rec != 0) m_rec--;
         if (m_mode == 1 && !s) begin
            m_mode = 0; m_row = (m_row + 1) % NROW;
         end else if (m_mode == 2 && !s) begin
            m_mode = 0; m_rec = REC;
         end else if (m_mode == 2) begin
            if (m_tmr == PER - 1) begin m_tmr = 0; m_pul = PUL; end
            else m_tmr++;
         end
         if (m_rise && !m_bz) begin
            if (sen)      begin m_mode = 2; m_tmr = 0; end
            else if (req) m_mode = 1;
         end
         m_sq = s;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         string tag;
         tag = (m_mode == 2 || m_pul != 0) ? "R6 model" :
               (m_rec != 0) ? "R8 model" : "R2 model";
         chk({tag, " row"},  int'(row),  m_row);
         chk({tag, " stb"},  int'(stb),  int'(m_mode == 1 || m_pul != 0));
         chk({tag, " busy"}, int'(busy), int'(m_mode != 0 || m_pul != 0 || m_rec != 0));
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      step(2);
      chk("R1 row in reset", int'(row), 0);
      chk("R1 stb in reset", int'(stb), 0);
      chk("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      step(1);
      chk("R1 row after reset", int'(row), 0);
      chk("R1 busy after reset", int'(busy), 0);

      // external refresh
      req = 1'b1; s = 1'b1;
      step(1);
      chk("R2 stb", int'(stb), 1);
      chk("R2 busy", int'(busy), 1);
      chk("R10 row held", int'(row), 0);
      step(1);
      chk("R10 row held 2", int'(row), 0);
      s = 1'b0; req = 1'b0;
      step(1);
      chk("R3 stb low", int'(stb), 0);
      chk("R3 row inc", int'(row), 1);
      chk("R3 busy low", int'(busy), 0);

      // plain strobe without request
      s = 1'b1;
      step(1);
      chk("R5 stb", int'(stb), 0);
      chk("R5 busy", int'(busy), 0);
      s = 1'b0;
      step(1);
      chk("R5 row", int'(row), 1);

      // run up to the wrap
      for (int i = 0; i < NROW - 2; i++) begin
         req = 1'b1; s = 1'b1; step(1);
         s = 1'b0; req = 1'b0; step(1);
      end
      chk("R4 top row", int'(row), NROW - 1);
      req = 1'b1; s = 1'b1; step(1);
      s = 1'b0; req = 1'b0; step(1);
      chk("R4 wrap", int'(row), 0);

      // self-refresh entry with both selects
      req = 1'b1; sen = 1'b1; s = 1'b1;
      step(1);
      chk("R7 no immediate stb", int'(stb), 0);
      chk("R7 busy", int'(busy), 1);
      req = 1'b0; sen = 1'b0;
      step(PER - 1);
      chk("R6 before first tick", int'(stb), 0);
      step(1);
      chk("R6 first pulse", int'(stb), 1);
      chk("R6 row during pulse", int'(row), 0);
      step(PUL);
      chk("R6 pulse end", int'(stb), 0);
      chk("R6 row inc", int'(row), 1);
      step(PER - PUL);
      chk("R6 second pulse", int'(stb), 1);

      // exit in mid-pulse
      s = 1'b0;
      step(1);
      chk("R8 busy at exit", int'(busy), 1);
      s = 1'b1; req = 1'b1;
      step(1);
      s = 1'b0; req = 1'b0;
      step(REC - 2);
      chk("R8 busy held", int'(busy), 1);
      step(1);
      chk("R8 busy released", int'(busy), 0);
      chk("R9 ignored stb", int'(stb), 0);
      chk("R9 row", int'(row), 2);

      // accepted again after recovery
      req = 1'b1; s = 1'b1;
      step(1);
      chk("R9 accept after", int'(stb), 1);
      s = 1'b0; req = 1'b0;
      step(2);
      chk("R10 row after", int'(row), 3);

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule